// File: doc/BRIEF.md
# Two-Step Egress Timestamp Reporter

This block sits beside the transmit path of an Ethernet MAC and serves two-step precision time protocol operation. When a frame begins and the caller marks it with a timestamp request, the block records the time-of-day at that frame start. It also records the caller's fingerprint tag. A fixed number of cycles later, the block hands the recorded time and the same fingerprint back on a separate report channel. A one-cycle valid strobe marks each report. Host software uses the fingerprint to pair each report with the frame it sent. The block never touches frame contents: it only observes the frame start.

Several requested frames may be in flight at once. Each pending capture waits in a small first-in first-out store until its due cycle, so reports leave in frame order. The store has a fixed depth. A request that arrives while the store is full is dropped and raises a sticky overflow flag; the frame stream is never stalled.

The controller follows the occupancy of the store with three states. OCC_EMPTY holds no pending capture. OCC_PARTIAL holds at least one capture and has free room. OCC_FULL holds DEPTH captures. The transitions are:
- OCC_EMPTY to OCC_PARTIAL on an accepted request.
- OCC_PARTIAL to OCC_FULL when a request is accepted with no report in the same cycle and DEPTH-1 entries already wait.
- OCC_PARTIAL to OCC_EMPTY when the last entry is reported with no new request accepted.
- OCC_FULL to OCC_PARTIAL when a report leaves with no new request accepted.

Top module: `egress_stamp_reporter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stamp_valid_o` and `overflow_o` are 0.
- R2: A capture happens only on a cycle where `frame_start_i` and `stamp_req_i` are both 1. A frame start without a request, or a request without a frame start, produces no report.
- R3: Each report carries on `stamp_fp_o` the fingerprint that was present on `stamp_fp_i` at its capture cycle.
- R4: Each report carries on `stamp_o` the 96-bit value that `tod_i` held at its capture edge.
- R5: Suppose a request is captured at clock edge E. Then `stamp_valid_o` is 1 for exactly the one cycle that follows edge E+LATENCY. LATENCY is a parameter with default 8.
- R6: Reports leave in the same order as the frames that requested them, including back-to-back requests on consecutive cycles.
- R7: A request is dropped, and `overflow_o` becomes 1 after that edge, when DEPTH captures are pending and none is reported in the same cycle. DEPTH is a parameter with default 4. If a report leaves in the same cycle, the request is accepted instead.
- R8: Once `overflow_o` is 1 it stays 1 until reset, regardless of later traffic.
- R9: DEPTH requests on consecutive cycles are all accepted and reported without raising `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle marker of the first cycle of a transmitted frame |
| stamp_req_i | input | 1 | Two-step timestamp request for the frame starting this cycle |
| stamp_fp_i | input | FP_W (4) | Fingerprint tag of the requesting frame |
| tod_i | input | 96 | Current time-of-day |
| stamp_valid_o | output | 1 | One-cycle strobe: a report is present |
| stamp_o | output | 96 | Captured egress time of the reported frame |
| stamp_fp_o | output | FP_W (4) | Fingerprint echoed with the report |
| overflow_o | output | 1 | Sticky flag: a request was dropped because the store was full |

## Verification
The in-design properties assume some things about the inputs. `frame_start_i` and `stamp_req_i` must be clean 0/1 values from the first cycle after reset. The time-of-day is treated as opaque data, so no monotonic behaviour is relied upon. LATENCY must stay below the wrap period of the internal cycle counter, which the derived counter width guarantees.

The stimulus drives all inputs on the falling clock edge, so each value is stable well before the rising edge that captures it. Requests come only as isolated pulses or as back-to-back bursts of chosen length. This lets the scoreboard predict every accept-or-drop decision from the count of reports still pending.

// File: rtl/egts_pkg.sv
package egts_pkg;

    // width of the captured time-of-day word
    localparam int TS_W = 96;

    // occupancy of the pending-capture store
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/egts_pending_fifo.sv
module egts_pending_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [W-1:0]  dout_o,
    output logic [CW-1:0] count_o
);

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // one storage register per slot, written only when selected
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && (wr_ptr_q == AW'(gi))) begin
                slot_q[gi] <= din_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) begin
                wr_ptr_q <= ptr_next(wr_ptr_q);
            end
            if (pop_i) begin
                rd_ptr_q <= ptr_next(rd_ptr_q);
            end
            unique case ({push_i, pop_i})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign dout_o  = slot_q[rd_ptr_q];
    assign count_o = count_q;

    // R9: the store never holds more than DEPTH captures
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R6: a report is only taken from a non-empty store
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count_q != '0));

endmodule

// File: rtl/egts_ctrl.sv
module egts_ctrl
    import egts_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int LATENCY = 8,
    parameter int CNT_W   = 5,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             stamp_req_i,
    input  logic [CW-1:0]    count_i,
    input  logic [CNT_W-1:0] head_due_i,
    output logic             push_o,
    output logic             pop_o,
    output logic [CNT_W-1:0] due_o,
    output logic             overflow_o
);

    occ_state_e       state_q;
    occ_state_e       state_d;
    logic [CNT_W-1:0] cyc_q;
    logic             ovf_q;
    logic             want_cap;

    assign want_cap = frame_start_i && stamp_req_i;

    // state register, free-running cycle counter and sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cyc_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cyc_q   <= cyc_q + CNT_W'(1);
            if (want_cap && !push_o) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_o) begin
                    state_d = OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (push_o && !pop_o && (count_i == CW'(DEPTH - 1))) begin
                    state_d = OCC_FULL;
                end else if (pop_o && !push_o && (count_i == CW'(1))) begin
                    state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (pop_o && !push_o) begin
                    state_d = OCC_PARTIAL;
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // outputs: report when the head entry is due, accept when room exists
    always_comb begin
        pop_o  = (state_q != OCC_EMPTY) && (head_due_i == cyc_q);
        push_o = want_cap && ((state_q != OCC_FULL) || pop_o);
        due_o  = cyc_q + CNT_W'(LATENCY);
    end

    assign overflow_o = ovf_q;

    // R7: a request meeting a full store with no report raises overflow
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (want_cap && (count_i == CW'(DEPTH)) && !pop_o) |=> overflow_o);

    // R8: overflow never clears without reset
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

endmodule

// File: rtl/egress_stamp_reporter.sv
module egress_stamp_reporter
    import egts_pkg::*;
#(
    parameter int FP_W    = 4,
    parameter int DEPTH   = 4,
    parameter int LATENCY = 8,
    localparam int CNT_W  = $clog2(LATENCY + 1) + 1,
    localparam int ENT_W  = FP_W + TS_W + CNT_W,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start_i,
    input  logic            stamp_req_i,
    input  logic [FP_W-1:0] stamp_fp_i,
    input  logic [TS_W-1:0] tod_i,
    output logic            stamp_valid_o,
    output logic [TS_W-1:0] stamp_o,
    output logic [FP_W-1:0] stamp_fp_o,
    output logic            overflow_o
);

    logic             push;
    logic             pop;
    logic [CNT_W-1:0] due;
    logic [ENT_W-1:0] head;
    logic [CW-1:0]    count;
    logic [FP_W-1:0]  head_fp;
    logic [TS_W-1:0]  head_ts;
    logic [CNT_W-1:0] head_due;

    assign {head_fp, head_ts, head_due} = head;

    egts_ctrl #(
        .DEPTH   (DEPTH),
        .LATENCY (LATENCY),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .stamp_req_i   (stamp_req_i),
        .count_i       (count),
        .head_due_i    (head_due),
        .push_o        (push),
        .pop_o         (pop),
        .due_o         (due),
        .overflow_o    (overflow_o)
    );

    egts_pending_fifo #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   ({stamp_fp_i, tod_i, due}),
        .pop_i   (pop),
        .dout_o  (head),
        .count_o (count)
    );

    // report register: one-cycle strobe, data held between reports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp_valid_o <= 1'b0;
            stamp_o       <= '0;
            stamp_fp_o    <= '0;
        end else begin
            stamp_valid_o <= pop;
            if (pop) begin
                stamp_o    <= head_ts;
                stamp_fp_o <= head_fp;
            end
        end
    end

    // R5: every strobe stems from a due entry one edge earlier
    p_report_from_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid_o |-> $past(pop));

    // R2: with no pending entry and no accepted request, nothing is reported next
    p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) && !push) |=> !stamp_valid_o);

endmodule

// File: tb/egress_stamp_reporter_bench.sv
module egress_stamp_reporter_bench;

    localparam int FP_W    = 4;
    localparam int DEPTH   = 4;
    localparam int LATENCY = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_start_i = 1'b0;
    logic            stamp_req_i = 1'b0;
    logic [FP_W-1:0] stamp_fp_i = '0;
    logic [95:0]     tod_i = '0;
    logic            stamp_valid_o;
    logic [95:0]     stamp_o;
    logic [FP_W-1:0] stamp_fp_o;
    logic            overflow_o;

    always #5 clk = ~clk;

    egress_stamp_reporter #(
        .FP_W    (FP_W),
        .DEPTH   (DEPTH),
        .LATENCY (LATENCY)
    ) u_egress_stamp_reporter (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .stamp_req_i   (stamp_req_i),
        .stamp_fp_i    (stamp_fp_i),
        .tod_i         (tod_i),
        .stamp_valid_o (stamp_valid_o),
        .stamp_o       (stamp_o),
        .stamp_fp_o    (stamp_fp_o),
        .overflow_o    (overflow_o)
    );

    typedef struct {
        int              due;
        logic [FP_W-1:0] fp;
        logic [95:0]     ts;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   edge_n = 0;
    bit   mon_en = 1'b0;
    bit   ovf_model = 1'b0;

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, predicting accept or drop
    task automatic drive(input bit sof, input bit req, input logic [FP_W-1:0] fp);
        bit   dropped;
        int   nxt;
        int   pend;
        exp_t e;
        dropped = 1'b0;
        @(negedge clk);
        nxt = edge_n + 1;
        frame_start_i = sof;
        stamp_req_i   = req;
        stamp_fp_i    = fp;
        tod_i = {32'hC0DE_0000 | 32'(nxt), 32'(nxt * 13), ~32'(nxt)};
        if (sof && req) begin
            pend = 0;
            foreach (q[i]) if (q[i].due > nxt) pend++;
            if (pend < DEPTH) begin
                e.due = nxt + LATENCY;
                e.fp  = fp;
                e.ts  = tod_i;
                q.push_back(e);
            end else begin
                dropped = 1'b1;
            end
        end
        @(posedge clk);
        if (dropped) ovf_model = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        frame_start_i = 1'b0;
        stamp_req_i = 1'b0;
        q.delete();
        ovf_model = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(stamp_valid_o == 1'b0, "R1", "valid in reset", 128'(stamp_valid_o), 0);
        check(overflow_o == 1'b0, "R1", "overflow in reset", 128'(overflow_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    // monitor: compare every cycle against the scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            if (q.size() > 0 && q[0].due == edge_n) begin
                exp_t e;
                e = q.pop_front();
                check(stamp_valid_o == 1'b1, "R5", "report strobe", 128'(stamp_valid_o), 1);
                if (stamp_valid_o) begin
                    check(stamp_fp_o == e.fp, "R3 R6", "fingerprint", 128'(stamp_fp_o), 128'(e.fp));
                    check(stamp_o == e.ts, "R4", "timestamp", 128'(stamp_o), 128'(e.ts));
                end
            end else begin
                check(stamp_valid_o == 1'b0, "R2 R5", "unexpected report", 128'(stamp_valid_o), 0);
            end
            check(overflow_o == ovf_model, "R7 R8", "overflow flag", 128'(overflow_o), 128'(ovf_model));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first cycle after reset
        #1;
        check(stamp_valid_o == 1'b0 && overflow_o == 1'b0, "R1", "outputs after reset",
              128'({stamp_valid_o, overflow_o}), 0);
        // single request
        drive(1'b1, 1'b1, 4'h3);
        idle(12);
        // R2: frame start alone, request alone
        drive(1'b1, 1'b0, 4'h9);
        drive(1'b0, 1'b1, 4'hA);
        idle(12);
        // spaced requests with a bare frame start between
        drive(1'b1, 1'b1, 4'h1);
        drive(1'b1, 1'b0, 4'hE);
        drive(1'b1, 1'b1, 4'h2);
        idle(12);
        // R9: exactly DEPTH back to back, no overflow
        for (int i = 0; i < DEPTH; i++) drive(1'b1, 1'b1, 4'(4 + i));
        idle(12);
        check(overflow_o == 1'b0, "R9", "overflow after DEPTH burst", 128'(overflow_o), 0);
        // R7: burst longer than DEPTH drops the tail
        for (int i = 0; i < 7; i++) drive(1'b1, 1'b1, 4'(8 + i));
        idle(12);
        check(overflow_o == 1'b1, "R7", "overflow after long burst", 128'(overflow_o), 1);
        // R7 exception: continuous requests, accepted again once reports leave
        for (int i = 0; i < 14; i++) drive(1'b1, 1'b1, 4'(i));
        idle(14);
        // R8: still set after quiet time, cleared by reset
        check(overflow_o == 1'b1, "R8", "overflow held", 128'(overflow_o), 1);
        do_reset();
        #1;
        check(overflow_o == 1'b0, "R8", "overflow after reset", 128'(overflow_o), 0);
        drive(1'b1, 1'b1, 4'hC);
        idle(12);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule